// File: doc/BRIEF.md
# Translation Lookaside Buffer with Permission Check

This block holds a small, fully associative set of recently used virtual-to-physical page translations and sits between the load, store and fetch logic and a page table walker. A lookup takes the 27-bit virtual page number from bits 38..12 of a 39-bit virtual address and compares it against every valid entry in parallel. When an entry matches, the block answers in the same cycle. The answer is a 56-bit physical address, made of the cached 44-bit physical page number with the 12-bit page offset appended. The block also checks the cached permission flags against the access kind and the privilege mode, so a hit can still end in a page fault.

When no valid entry matches, the block stalls the requester and raises a walk request carrying the page number. The walker's answer is installed into the slot chosen by a round-robin pointer, and the held request then hits. A walk that reports a fault is returned to the requester as a fault and is never cached. A flush input drops every cached translation at once. It is meant to be pulsed whenever the register that holds the root page table address is rewritten.

Top module: `xlt_cache`

## Requirements
- R1: After reset no entry is valid, resp_valid_o and walk_req_o are low, and the first lookup of any page misses.
- R2: When req_valid_i is high, no walk is pending, and a valid entry's page number equals req_vaddr_i[38:12], resp_valid_o rises in the same cycle. Unless the access faults, resp_paddr_o equals {cached page number, req_vaddr_i[11:0]}.
- R3: A lookup that misses gives no response in that cycle. From the next cycle, walk_req_o is high and walk_vpn_o carries the missed page number. Both hold unchanged until walk_done_i. While walk_req_o is high, req inputs are ignored.
- R4: req_kind_i encodes the access: 0 is a read and needs R (walk_perm_i[0]), 1 is a write and needs W (bit 1), 2 is a fetch and needs X (bit 2), and 3 is reserved and always faults. A missing permission gives resp_fault_o=1 with resp_paddr_o=0.
- R5: With req_user_i=1, an access to a page whose U flag (walk_perm_i[3]) is clear faults. With req_user_i=0, the U flag places no restriction.
- R6: A walk_done_i with walk_fault_i=0 installs {page number, walk_ppn_i, walk_perm_i} at that clock edge. The held request hits in the following cycle.
- R7: A walk_done_i with walk_fault_i=1 raises resp_valid_o and resp_fault_o in that same cycle and installs nothing, so a later lookup of that page walks again.
- R8: Installs go to the slot named by a pointer that advances by one per install and wraps after 8. The ninth distinct install after a flush evicts the first.
- R9: flush_i clears every valid bit and resets the replacement pointer, taking effect from the next cycle. A walk result completing in the same cycle as flush_i is not installed.
- R10: A slot whose valid bit is clear never hits, even if the page number it still holds equals the lookup's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all cached translations |
| req_valid_i | input | 1 | Lookup request, held until resp_valid_o |
| req_vaddr_i | input | 39 | Virtual address of the access |
| req_kind_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| req_user_i | input | 1 | 1 for user mode, 0 for supervisor mode |
| resp_valid_o | output | 1 | Response for the current request |
| resp_fault_o | output | 1 | Page fault for the current request |
| resp_paddr_o | output | 56 | Translated physical address, zero on fault |
| walk_req_o | output | 1 | Walk pending |
| walk_vpn_o | output | 27 | Page number to be walked |
| walk_done_i | input | 1 | Walker result valid |
| walk_ppn_i | input | 44 | Physical page number from the walker |
| walk_perm_i | input | 4 | Flags {U,X,W,R} from the walker |
| walk_fault_i | input | 1 | Walker found no valid translation |

## Verification
The assertions watch several properties on every cycle. They check that at most one slot matches a lookup and that a pending walk holds its request and page number steady. They also check that a miss always leads to a walk, that no response leaves while a walk is pending except a walk fault, that a faulting response carries a zero address, that a user access to a supervisor page faults, that a flush is followed by a miss, and that the replacement pointer steps by one per install. Some behaviour needs whole access sequences, so only the bench scenarios can show it. That covers which entry a ninth page evicts, that a faulting or flush-coincident walk leaves no entry behind, and that stale contents in a cleared slot never answer.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
    localparam int VA_W  = 39;
    localparam int PA_W  = 56;
    localparam int OFF_W = 12;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;

    typedef struct packed {
        logic u;
        logic x;
        logic w;
        logic r;
    } perm_t;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
        perm_t            perm;
    } xlt_ent_t;
endpackage

// File: rtl/xlt_perm_check.sv
module xlt_perm_check
    import xlt_pkg::*;
(
    input  perm_t      perm_i,
    input  logic [1:0] kind_i,
    input  logic       user_i,
    output logic       deny_o
);
    logic kind_ok;

    always_comb begin
        case (acc_e'(kind_i))
            ACC_READ:  kind_ok = perm_i.r;
            ACC_WRITE: kind_ok = perm_i.w;
            ACC_FETCH: kind_ok = perm_i.x;
            default:   kind_ok = 1'b0;
        endcase
        deny_o = !kind_ok || (user_i && !perm_i.u);
    end
endmodule

// File: rtl/xlt_victim.sv
module xlt_victim #(
    parameter  int ENTRIES = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             advance_i,
    output logic [IDX_W-1:0] idx_o
);
    typedef struct packed {
        logic [IDX_W-1:0] ptr;
    } vic_st_t;

    vic_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.ptr = '0;
        end else if (advance_i) begin
            st_d.ptr = (st_q.ptr == IDX_W'(ENTRIES - 1)) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx_o = st_q.ptr;

    p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        advance_i && !clear_i |=> idx_o == (($past(idx_o) == IDX_W'(ENTRIES - 1)) ? '0 : $past(idx_o) + 1'b1));

    p_ptr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> idx_o == '0);
endmodule

// File: rtl/xlt_entry_array.sv
module xlt_entry_array
    import xlt_pkg::*;
#(
    parameter  int ENTRIES = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             fill_i,
    input  logic [IDX_W-1:0] fill_idx_i,
    input  xlt_ent_t         fill_ent_i,
    input  logic [VPN_W-1:0] look_vpn_i,
    output logic             hit_o,
    output xlt_ent_t         hit_ent_o
);
    typedef struct packed {
        logic [ENTRIES-1:0]       valid;
        xlt_ent_t [ENTRIES-1:0]   ent;
    } arr_st_t;

    arr_st_t            st_d, st_q;
    logic [ENTRIES-1:0] hit_vec;

    // Match needs the valid bit: a cleared slot's old tag never answers.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = st_q.valid[g] && (st_q.ent[g].vpn == look_vpn_i);
    end

    always_comb begin
        hit_ent_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_ent_o = xlt_ent_t'(hit_ent_o | st_q.ent[i]);
        end
        hit_o = |hit_vec;
    end

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d.valid = '0;
        end else if (fill_i) begin
            st_d.valid[fill_idx_i] = 1'b1;
            st_d.ent[fill_idx_i]   = fill_ent_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_onehot_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    p_flush_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !hit_o);
endmodule

// File: rtl/xlt_cache.sv
module xlt_cache
    import xlt_pkg::*;
#(
    parameter  int ENTRIES = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             req_valid_i,
    input  logic [VA_W-1:0]  req_vaddr_i,
    input  logic [1:0]       req_kind_i,
    input  logic             req_user_i,
    output logic             resp_valid_o,
    output logic             resp_fault_o,
    output logic [PA_W-1:0]  resp_paddr_o,
    output logic             walk_req_o,
    output logic [VPN_W-1:0] walk_vpn_o,
    input  logic             walk_done_i,
    input  logic [PPN_W-1:0] walk_ppn_i,
    input  logic [3:0]       walk_perm_i,
    input  logic             walk_fault_i
);
    typedef enum logic {S_IDLE, S_WALK} fsm_e;

    typedef struct packed {
        fsm_e             state;
        logic [VPN_W-1:0] vpn;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic [VPN_W-1:0] look_vpn;
    logic             hit;
    xlt_ent_t         hit_ent;
    logic             deny;
    logic             fill;
    logic [IDX_W-1:0] fill_idx;
    xlt_ent_t         fill_ent;

    assign look_vpn = req_vaddr_i[VA_W-1:OFF_W];
    assign fill_ent = '{vpn: st_q.vpn, ppn: walk_ppn_i, perm: perm_t'(walk_perm_i)};

    xlt_entry_array #(.ENTRIES(ENTRIES)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush_i),
        .fill_i     (fill),
        .fill_idx_i (fill_idx),
        .fill_ent_i (fill_ent),
        .look_vpn_i (look_vpn),
        .hit_o      (hit),
        .hit_ent_o  (hit_ent)
    );

    xlt_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (flush_i),
        .advance_i (fill),
        .idx_o     (fill_idx)
    );

    xlt_perm_check u_perm (
        .perm_i (hit_ent.perm),
        .kind_i (req_kind_i),
        .user_i (req_user_i),
        .deny_o (deny)
    );

    always_comb begin
        st_d         = st_q;
        resp_valid_o = 1'b0;
        resp_fault_o = 1'b0;
        resp_paddr_o = '0;
        fill         = 1'b0;
        case (st_q.state)
            S_IDLE: begin
                if (req_valid_i) begin
                    if (hit) begin
                        resp_valid_o = 1'b1;
                        resp_fault_o = deny;
                        if (!deny) resp_paddr_o = {hit_ent.ppn, req_vaddr_i[OFF_W-1:0]};
                    end else begin
                        st_d.state = S_WALK;
                        st_d.vpn   = look_vpn;
                    end
                end
            end
            default: begin
                if (walk_done_i) begin
                    st_d.state = S_IDLE;
                    if (walk_fault_i) begin
                        resp_valid_o = 1'b1;
                        resp_fault_o = 1'b1;
                    end else begin
                        // A result racing a flush belongs to the old table.
                        fill = !flush_i;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: S_IDLE, vpn: '0};
        else        st_q <= st_d;
    end

    assign walk_req_o = (st_q.state == S_WALK);
    assign walk_vpn_o = st_q.vpn;

    p_miss_walks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && !walk_req_o && !resp_valid_o |=> walk_req_o);

    p_walk_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_o && !walk_done_i |=> walk_req_o && $stable(walk_vpn_o));

    p_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_o && !(walk_done_i && walk_fault_i) |-> !resp_valid_o);

    p_fault_nopa_r4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid_o && resp_fault_o |-> resp_paddr_o == '0);

    p_user_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid_o && !walk_req_o && req_user_i && hit && !hit_ent.perm.u |-> resp_fault_o);
endmodule

// File: tb/xlt_cache_test.sv
module xlt_cache_test;
    localparam int NE = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [38:0] req_vaddr_i = '0;
    logic [1:0]  req_kind_i = '0;
    logic        req_user_i = 1'b0;
    logic        resp_valid_o, resp_fault_o, walk_req_o;
    logic [55:0] resp_paddr_o;
    logic [26:0] walk_vpn_o;
    logic        walk_done_i = 1'b0;
    logic [43:0] walk_ppn_i = '0;
    logic [3:0]  walk_perm_i = '0;
    logic        walk_fault_i = 1'b0;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    bit flush_on_done = 0;

    always #5 clk = ~clk;

    xlt_cache uut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .req_valid_i(req_valid_i), .req_vaddr_i(req_vaddr_i),
        .req_kind_i(req_kind_i), .req_user_i(req_user_i),
        .resp_valid_o(resp_valid_o), .resp_fault_o(resp_fault_o),
        .resp_paddr_o(resp_paddr_o), .walk_req_o(walk_req_o),
        .walk_vpn_o(walk_vpn_o), .walk_done_i(walk_done_i),
        .walk_ppn_i(walk_ppn_i), .walk_perm_i(walk_perm_i),
        .walk_fault_i(walk_fault_i)
    );

    // Page attributes seen by the bench walker.
    function automatic logic [43:0] ppn_of(logic [26:0] v);
        return {17'h1A5, v};
    endfunction
    function automatic logic [3:0] perm_of(logic [26:0] v); // {U,X,W,R}
        case (v)
            27'h20:  return 4'b0001;
            27'h30:  return 4'b1111;
            default: return 4'b0111;
        endcase
    endfunction
    function automatic bit bad_of(logic [26:0] v);
        return v == 27'h40;
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference model.
    bit          m_valid [NE];
    logic [26:0] m_vpn   [NE];
    logic [43:0] m_ppn   [NE];
    logic [3:0]  m_perm  [NE];
    int          m_ptr;
    bit          m_walk;
    logic [26:0] m_wvpn;

    function automatic int m_find(logic [26:0] v);
        for (int i = 0; i < NE; i++) if (m_valid[i] && m_vpn[i] == v) return i;
        return -1;
    endfunction

    function automatic bit m_deny(logic [3:0] p, logic [1:0] k, logic u);
        bit ok;
        if (k == 2'd0)      ok = p[0];
        else if (k == 2'd1) ok = p[1];
        else if (k == 2'd2) ok = p[2];
        else                ok = 0;
        if (u && !p[3]) ok = 0;
        return !ok;
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (!finished) begin
                bit ev, ef;
                logic [55:0] ep;
                int h;
                ev = 0; ef = 0; ep = '0;
                h = m_find(req_vaddr_i[38:12]);
                if (!m_walk && req_valid_i && h >= 0) begin
                    ev = 1;
                    ef = m_deny(m_perm[h], req_kind_i, req_user_i);
                    if (!ef) ep = {m_ppn[h], req_vaddr_i[11:0]};
                end else if (m_walk && walk_done_i && walk_fault_i) begin
                    ev = 1; ef = 1;
                end
                chk(resp_valid_o === ev, "R2", "resp_valid", 64'(resp_valid_o), 64'(ev));
                chk(resp_fault_o === ef, "R4", "resp_fault", 64'(resp_fault_o), 64'(ef));
                chk(resp_paddr_o === ep, "R2", "resp_paddr", 64'(resp_paddr_o), 64'(ep));
                chk(walk_req_o === m_walk, "R3", "walk_req", 64'(walk_req_o), 64'(m_walk));
                if (m_walk)
                    chk(walk_vpn_o === m_wvpn, "R3", "walk_vpn", 64'(walk_vpn_o), 64'(m_wvpn));
            end
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NE; i++) m_valid[i] = 0;
            m_ptr = 0; m_walk = 0; m_wvpn = '0;
        end else begin
            if (!m_walk) begin
                if (req_valid_i && m_find(req_vaddr_i[38:12]) < 0) begin
                    m_walk = 1; m_wvpn = req_vaddr_i[38:12];
                end
            end else if (walk_done_i) begin
                m_walk = 0;
                if (!walk_fault_i && !flush_i) begin
                    m_valid[m_ptr] = 1; m_vpn[m_ptr] = m_wvpn;
                    m_ppn[m_ptr] = walk_ppn_i; m_perm[m_ptr] = walk_perm_i;
                    m_ptr = (m_ptr + 1) % NE;
                end
            end
            if (flush_i) begin
                for (int i = 0; i < NE; i++) m_valid[i] = 0;
                m_ptr = 0;
            end
        end
    end

    // One access held until answered; acts as walker with a 2-cycle delay.
    task automatic access(input logic [26:0] v, input logic [11:0] off, input logic [1:0] k,
                          input logic u, output int walks, output bit flt, output logic [55:0] pa);
        int dly;
        bit got;
        walks = 0; flt = 0; pa = '0; dly = 0; got = 0;
        @(negedge clk);
        req_valid_i = 1; req_vaddr_i = {v, off}; req_kind_i = k; req_user_i = u;
        for (int cyc = 0; cyc < 60 && !got; cyc++) begin
            #3;
            if (resp_valid_o) begin
                got = 1; flt = resp_fault_o; pa = resp_paddr_o;
            end
            @(negedge clk);
            walk_done_i = 0; flush_i = 0;
            if (!got && walk_req_o) begin
                dly++;
                if (dly == 2) begin
                    walk_done_i = 1; walk_ppn_i = ppn_of(walk_vpn_o);
                    walk_perm_i = perm_of(walk_vpn_o); walk_fault_i = bad_of(walk_vpn_o);
                    walks++; dly = 0;
                    if (flush_on_done) begin flush_i = 1; flush_on_done = 0; end
                end
            end
        end
        req_valid_i = 0; walk_done_i = 0; flush_i = 0;
        chk(got, "R3", "response arrived", 64'(got), 64'd1);
    endtask

    task automatic do_flush();
        @(negedge clk); flush_i = 1;
        @(negedge clk); flush_i = 0;
    endtask

    task automatic expect_acc(string tag, logic [26:0] v, logic [11:0] off, logic [1:0] k,
                              logic u, int ew, bit ef);
        int w; bit f; logic [55:0] pa;
        access(v, off, k, u, w, f, pa);
        chk(w == ew, tag, "walk count", 64'(w), 64'(ew));
        chk(f == ef, tag, "fault", 64'(f), 64'(ef));
        if (!ef) chk(pa == {ppn_of(v), off}, tag, "paddr", 64'(pa), 64'({ppn_of(v), off}));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #3;
        chk(resp_valid_o === 1'b0, "R1", "resp_valid in reset", 64'(resp_valid_o), 64'd0);
        chk(walk_req_o === 1'b0, "R1", "walk_req in reset", 64'(walk_req_o), 64'd0);
        @(negedge clk); rst_n = 1;
        // R1/R2/R6: first access misses, then hits
        expect_acc("R1", 27'h10, 12'h0AB, 2'd0, 0, 1, 0);
        expect_acc("R6", 27'h10, 12'h123, 2'd1, 0, 0, 0);
        expect_acc("R2", 27'h10, 12'hFFF, 2'd2, 0, 0, 0);
        // R4: read-only page
        expect_acc("R4", 27'h20, 12'h004, 2'd1, 0, 1, 1);
        expect_acc("R4", 27'h20, 12'h008, 2'd0, 0, 0, 0);
        expect_acc("R4", 27'h20, 12'h00C, 2'd2, 0, 0, 1);
        expect_acc("R4", 27'h20, 12'h010, 2'd3, 0, 0, 1);
        // R5: user-mode rules
        expect_acc("R5", 27'h10, 12'h020, 2'd0, 1, 0, 1);
        expect_acc("R5", 27'h30, 12'h040, 2'd0, 1, 1, 0);
        expect_acc("R5", 27'h30, 12'h044, 2'd2, 1, 0, 0);
        expect_acc("R5", 27'h10, 12'h048, 2'd0, 0, 0, 0);
        // R7: faulting walk never cached
        expect_acc("R7", 27'h40, 12'h000, 2'd0, 0, 1, 1);
        expect_acc("R7", 27'h40, 12'h000, 2'd0, 0, 1, 1);
        // R9/R10: flush drops entries whose data remain in place
        do_flush();
        expect_acc("R10", 27'h10, 12'h050, 2'd0, 0, 1, 0);
        // R9: result racing a flush is dropped
        flush_on_done = 1;
        expect_acc("R9", 27'h50, 12'h060, 2'd0, 0, 2, 0);
        expect_acc("R9", 27'h50, 12'h064, 2'd0, 0, 0, 0);
        // R8: round-robin eviction after flush
        do_flush();
        for (int i = 0; i < NE; i++) expect_acc("R8", 27'h100 + 27'(i), 12'h0, 2'd0, 0, 1, 0);
        for (int i = 0; i < NE; i++) expect_acc("R8", 27'h100 + 27'(i), 12'h4, 2'd0, 0, 0, 0);
        expect_acc("R8", 27'h108, 12'h0, 2'd0, 0, 1, 0);
        expect_acc("R8", 27'h101, 12'h0, 2'd0, 0, 0, 0);
        expect_acc("R8", 27'h100, 12'h0, 2'd0, 0, 1, 0);
        expect_acc("R8", 27'h101, 12'h0, 2'd0, 0, 1, 0);
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule